// File: doc/BRIEF.md
# Nested Trap State Stack

This block keeps the processor context across nested traps. When a trap request arrives, it packs the current condition codes, address-space identifier, processor state and window pointer into a single state word. It stores that word in the slot for the current trap level, together with the program counter, the next program counter and the 9-bit trap type. It then forces a privileged processor state and sends the pipeline to a vector formed from the trap base address. A return command pops the most recent slot. A retry command re-executes the trapped instruction. A done command skips it. In both cases the saved context comes back on the outputs.

The packed state word keeps its fixed layout: window pointer in the low byte, processor state in bits 19:8, address-space identifier in bits 31:24, condition codes from bit 32 upward. Only the bits selected by mask 0xF3F of the processor state are kept. The stack depth equals the maximum trap level. The slot index is the trap level before entry, which is also the level after the matching return. All outputs are registered and change on the clock edge that samples the command. The redirect strobe, the error-state strobe and the illegal-return strobe are one-cycle pulses.

Top module: `trap_stack`

## Requirements
- R1: While `rst` is high, and on the first sampling after it, `trap_level` is 0 and `redirect_vld`, `error_state` and `illegal_ret` are all 0.
- R2: The processor state saved on entry keeps only the bits of mask 0xF3F; a return of a level entered with state 0xFFF yields `new_pstate` = 0xF3F.
- R3: On a trap accepted at level L, one cycle later `redirect_vld` is 1, `new_pc` = {`tba_hi`, (L > 1), `trap_type`, 5'b00000} and `new_npc` = `new_pc` + 4.
- R4: On an accepted trap, `new_pstate` = 0x015 (alternate globals bit 0, privileged bit 2, FP enable bit 4), `new_tt` = `trap_type`, and `new_cc`, `new_asi`, `new_cwp` echo the current inputs.
- R5: An accepted trap raises `trap_level` by exactly one; a pop lowers it by exactly one.
- R6: A trap accepted at level MAX_LVL-1 or higher additionally sets bit 5 (red state), giving `new_pstate` = 0x035.
- R7: A trap arriving at level MAX_LVL produces an `error_state` pulse with no redirect, leaves `trap_level` unchanged and saves nothing.
- R8: A retry command (`ret_cmd` = 2'b01) at level L > 0 gives `new_pc` = the saved PC and `new_npc` = the saved next PC of slot L-1.
- R9: A done command (`ret_cmd` = 2'b10) at level L > 0 gives `new_pc` = the saved next PC and `new_npc` = the saved next PC + 4.
- R10: Both return commands restore `new_cc`, `new_asi`, `new_cwp` and the saved trap type on `new_tt` from the popped slot.
- R11: A retry or done command at level 0 is ignored: `illegal_ret` pulses, with no redirect and `trap_level` staying 0.
- R12: A trap request takes priority over a return command in the same cycle, and `ret_cmd` = 2'b11 has no effect on outputs or level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap entry request |
| trap_type | input | 9 | Trap type of the request |
| ret_cmd | input | 2 | 00 none, 01 retry, 10 done, 11 reserved |
| tba_hi | input | PC_W-15 | Upper bits of the trap base address |
| cur_pc | input | PC_W | Current program counter |
| cur_npc | input | PC_W | Current next program counter |
| cur_cc | input | CC_W | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor state |
| cur_cwp | input | 8 | Current window pointer |
| redirect_vld | output | 1 | One-cycle pulse: new PC and state are valid |
| new_pc | output | PC_W | Redirect program counter |
| new_npc | output | PC_W | Redirect next program counter |
| new_cc | output | CC_W | Condition codes to install |
| new_asi | output | 8 | Address-space identifier to install |
| new_pstate | output | 12 | Processor state to install |
| new_cwp | output | 8 | Window pointer to install |
| new_tt | output | 9 | Trap type entered or popped |
| trap_level | output | clog2(MAX_LVL+1) | Current trap level |
| error_state | output | 1 | Pulse: trap arrived at the maximum level |
| illegal_ret | output | 1 | Pulse: return command at level 0 |

## Verification
The stack is driven through a full climb from level 0 to the maximum. The trap types have their high and low bits set in different patterns, and the processor states include all-ones, so the mask, the level-dependent vector bit and the red-state switch each show up on their own. One extra trap at the top must fault without disturbing the stored slots. The pops then mix retry and done with a reserved command in between, which separates the two program-counter selections and shows that each level restores its own slot rather than a neighbour's. Directed cases cover a return at level 0, trap and return together, and a reset taken with a non-empty stack.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;

  // fixed positions of the packed state word fields
  localparam int CC_LSB  = 32;
  localparam int ASI_LSB = 24;
  localparam int PS_LSB  = 8;
  localparam int CWP_LSB = 0;

  localparam int ASI_W = 8;
  localparam int PS_W  = 12;
  localparam int CWP_W = 8;
  localparam int TT_W  = 9;
  localparam int VEC_SHIFT = 5;

  localparam logic [PS_W-1:0] PS_KEEP  = 12'hF3F;
  localparam logic [PS_W-1:0] PS_AG    = 12'h001;
  localparam logic [PS_W-1:0] PS_PRIV  = 12'h004;
  localparam logic [PS_W-1:0] PS_FPEN  = 12'h010;
  localparam logic [PS_W-1:0] PS_RED   = 12'h020;
  localparam logic [PS_W-1:0] PS_ENTRY = PS_AG | PS_PRIV | PS_FPEN;

  typedef enum logic [1:0] {
    RET_NONE  = 2'b00,
    RET_RETRY = 2'b01,
    RET_DONE  = 2'b10,
    RET_RSVD  = 2'b11
  } ret_cmd_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_ENTER,
    ACT_FAULT,
    ACT_POP,
    ACT_BADRET
  } stk_act_e;

endpackage

// File: rtl/tsk_word_codec.sv
module tsk_word_codec
  import trap_stack_pkg::*;
#(
  parameter int CC_W = 8,
  localparam int WORD_W = CC_LSB + CC_W
) (
  input  logic [CC_W-1:0]   pk_cc,
  input  logic [ASI_W-1:0]  pk_asi,
  input  logic [PS_W-1:0]   pk_ps,
  input  logic [CWP_W-1:0]  pk_cwp,
  output logic [WORD_W-1:0] pk_word,
  input  logic [WORD_W-1:0] up_word,
  output logic [CC_W-1:0]   up_cc,
  output logic [ASI_W-1:0]  up_asi,
  output logic [PS_W-1:0]   up_ps,
  output logic [CWP_W-1:0]  up_cwp
);

  localparam int PS_SLOT = ASI_LSB - PS_LSB;

  logic [PS_SLOT-1:0] up_ps_slot;

  always_comb begin
    pk_word = '0;
    pk_word[CC_LSB  +: CC_W]  = pk_cc;
    pk_word[ASI_LSB +: ASI_W] = pk_asi;
    pk_word[PS_LSB  +: PS_W]  = pk_ps & PS_KEEP;
    pk_word[CWP_LSB +: CWP_W] = pk_cwp;
  end

  assign up_cc      = up_word[CC_LSB  +: CC_W];
  assign up_asi     = up_word[ASI_LSB +: ASI_W];
  assign up_ps_slot = up_word[PS_LSB  +: PS_SLOT];
  assign up_ps      = PS_W'(up_ps_slot & PS_SLOT'(PS_KEEP));
  assign up_cwp     = up_word[CWP_LSB +: CWP_W];

endmodule

// File: rtl/tsk_level_ctl.sv
module tsk_level_ctl
  import trap_stack_pkg::*;
#(
  parameter int MAX_LVL = 5,
  localparam int LVL_W = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_req,
  input  ret_cmd_e         ret_cmd,
  output logic [LVL_W-1:0] lvl,
  output stk_act_e         act,
  output logic [LVL_W-1:0] slot_idx,
  output logic             red_zone,
  output logic             deep_lvl
);

  localparam logic [LVL_W-1:0] TOP = LVL_W'(MAX_LVL);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  logic is_ret;

  assign is_ret = (ret_cmd == RET_RETRY) || (ret_cmd == RET_DONE);

  always_comb begin
    act = ACT_IDLE;
    if (trap_req) begin
      act = (lvl == TOP) ? ACT_FAULT : ACT_ENTER;
    end else if (is_ret) begin
      act = (lvl == '0) ? ACT_BADRET : ACT_POP;
    end
  end

  assign slot_idx = (act == ACT_POP) ? (lvl - ONE) : lvl;
  assign red_zone = (lvl >= (TOP - ONE));
  assign deep_lvl = (lvl > ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
    end else begin
      case (act)
        ACT_ENTER: lvl <= lvl + ONE;
        ACT_POP:   lvl <= lvl - ONE;
        default:   lvl <= lvl;
      endcase
    end
  end

endmodule

// File: rtl/tsk_slot_ram.sv
module tsk_slot_ram #(
  parameter int DEPTH = 5,
  parameter int WIDTH = 64,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/trap_stack.sv
module trap_stack
  import trap_stack_pkg::*;
#(
  parameter int MAX_LVL = 5,
  parameter int PC_W    = 64,
  parameter int CC_W    = 8,
  localparam int LVL_W  = $clog2(MAX_LVL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_req,
  input  logic [TT_W-1:0]    trap_type,
  input  logic [1:0]         ret_cmd,
  input  logic [PC_W-16:0]   tba_hi,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [PC_W-1:0]    cur_npc,
  input  logic [CC_W-1:0]    cur_cc,
  input  logic [ASI_W-1:0]   cur_asi,
  input  logic [PS_W-1:0]    cur_pstate,
  input  logic [CWP_W-1:0]   cur_cwp,
  output logic               redirect_vld,
  output logic [PC_W-1:0]    new_pc,
  output logic [PC_W-1:0]    new_npc,
  output logic [CC_W-1:0]    new_cc,
  output logic [ASI_W-1:0]   new_asi,
  output logic [PS_W-1:0]    new_pstate,
  output logic [CWP_W-1:0]   new_cwp,
  output logic [TT_W-1:0]    new_tt,
  output logic [LVL_W-1:0]   trap_level,
  output logic               error_state,
  output logic               illegal_ret
);

  localparam int WORD_W = CC_LSB + CC_W;
  localparam int ENT_W  = WORD_W + 2 * PC_W + TT_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  ret_cmd_e         cmd;
  stk_act_e         act;
  logic [LVL_W-1:0] slot_idx;
  logic             red_zone;
  logic             deep_lvl;

  logic [WORD_W-1:0] wr_word, rd_word;
  logic [ENT_W-1:0]  wr_ent, rd_ent;
  logic [CC_W-1:0]   rd_cc;
  logic [ASI_W-1:0]  rd_asi;
  logic [PS_W-1:0]   rd_ps;
  logic [CWP_W-1:0]  rd_cwp;
  logic [PC_W-1:0]   rd_pc, rd_npc;
  logic [TT_W-1:0]   rd_tt;
  logic [PC_W-1:0]   vec_pc;

  assign cmd = ret_cmd_e'(ret_cmd);

  tsk_level_ctl #(.MAX_LVL(MAX_LVL)) lvl_i (
    .clk      (clk),
    .rst      (rst),
    .trap_req (trap_req),
    .ret_cmd  (cmd),
    .lvl      (trap_level),
    .act      (act),
    .slot_idx (slot_idx),
    .red_zone (red_zone),
    .deep_lvl (deep_lvl)
  );

  tsk_word_codec #(.CC_W(CC_W)) codec_i (
    .pk_cc   (cur_cc),
    .pk_asi  (cur_asi),
    .pk_ps   (cur_pstate),
    .pk_cwp  (cur_cwp),
    .pk_word (wr_word),
    .up_word (rd_word),
    .up_cc   (rd_cc),
    .up_asi  (rd_asi),
    .up_ps   (rd_ps),
    .up_cwp  (rd_cwp)
  );

  assign wr_ent = {wr_word, cur_pc, cur_npc, trap_type};
  assign {rd_word, rd_pc, rd_npc, rd_tt} = rd_ent;

  tsk_slot_ram #(.DEPTH(MAX_LVL), .WIDTH(ENT_W), .AW(LVL_W)) ram_i (
    .clk   (clk),
    .we    (act == ACT_ENTER),
    .addr  (slot_idx),
    .wdata (wr_ent),
    .rdata (rd_ent)
  );

  // vector: base upper bits, deep-level bit, type, 32-byte slot
  assign vec_pc = {tba_hi, deep_lvl, trap_type, {VEC_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_vld <= 1'b0;
      error_state  <= 1'b0;
      illegal_ret  <= 1'b0;
      new_pc       <= '0;
      new_npc      <= '0;
      new_cc       <= '0;
      new_asi      <= '0;
      new_pstate   <= '0;
      new_cwp      <= '0;
      new_tt       <= '0;
    end else begin
      redirect_vld <= (act == ACT_ENTER) || (act == ACT_POP);
      error_state  <= (act == ACT_FAULT);
      illegal_ret  <= (act == ACT_BADRET);
      case (act)
        ACT_ENTER: begin
          new_pc     <= vec_pc;
          new_npc    <= vec_pc + STEP;
          new_cc     <= cur_cc;
          new_asi    <= cur_asi;
          new_pstate <= PS_ENTRY | (red_zone ? PS_RED : '0);
          new_cwp    <= cur_cwp;
          new_tt     <= trap_type;
        end
        ACT_POP: begin
          if (cmd == RET_DONE) begin
            new_pc  <= rd_npc;
            new_npc <= rd_npc + STEP;
          end else begin
            new_pc  <= rd_pc;
            new_npc <= rd_npc;
          end
          new_cc     <= rd_cc;
          new_asi    <= rd_asi;
          new_pstate <= rd_ps;
          new_cwp    <= rd_cwp;
          new_tt     <= rd_tt;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/trap_stack_chk.sv
module trap_stack_chk #(
  parameter int MAX_LVL = 5,
  parameter int PC_W    = 64,
  localparam int LVL_W  = $clog2(MAX_LVL + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             trap_req,
  input logic [1:0]       ret_cmd,
  input logic [LVL_W-1:0] trap_level,
  input logic             redirect_vld,
  input logic             error_state,
  input logic             illegal_ret,
  input logic [PC_W-1:0]  new_pc,
  input logic [PC_W-1:0]  new_npc,
  input logic [11:0]      new_pstate
);

  localparam logic [LVL_W-1:0] TOP = LVL_W'(MAX_LVL);

  // R3
  entry_npc_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level < TOP) |=> (new_npc == new_pc + PC_W'(4)) && (new_pc[4:0] == 5'd0));

  // R4
  entry_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level < TOP) |=> (new_pstate[0] && new_pstate[2] && new_pstate[4]));

  // R5
  level_up_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level < TOP) |=> (trap_level == $past(trap_level) + 1'b1));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    trap_level <= TOP);

  // R7
  fault_top_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_level == TOP) |=> (error_state && !redirect_vld && $stable(trap_level)));

  // R11
  bad_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && (ret_cmd == 2'b01 || ret_cmd == 2'b10) && trap_level == '0)
      |=> (illegal_ret && !redirect_vld && trap_level == '0));

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect_vld, error_state, illegal_ret}));

endmodule

bind trap_stack trap_stack_chk #(.MAX_LVL(MAX_LVL), .PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .trap_req     (trap_req),
  .ret_cmd      (ret_cmd),
  .trap_level   (trap_level),
  .redirect_vld (redirect_vld),
  .error_state  (error_state),
  .illegal_ret  (illegal_ret),
  .new_pc       (new_pc),
  .new_npc      (new_npc),
  .new_pstate   (new_pstate)
);

// File: tb/trap_stack_tb_top.sv
`timescale 1ns/1ps
module trap_stack_tb_top;

  localparam int MAXL = 5;
  localparam int PCW  = 64;
  localparam int LW   = $clog2(MAXL + 1);
  localparam logic [PCW-16:0] TBA_HI = 49'h0_F00D_CAFE_8001;

  // op(2) tt(9) cc(8) asi(8) ps(12) cwp(8) pc(32); op 0 trap, 1 retry, 2 done, 3 reserved
  localparam logic [78:0] VEC [15] = '{
    {2'd0, 9'h041, 8'hA5, 8'h80, 12'hFFF, 8'h03, 32'h0000_1000},
    {2'd0, 9'h1FF, 8'h3C, 8'h14, 12'h0C0, 8'h07, 32'h0040_2000},
    {2'd0, 9'h100, 8'h00, 8'hFF, 12'h0AA, 8'h01, 32'h1234_5670},
    {2'd0, 9'h024, 8'hFF, 8'h00, 12'h555, 8'h05, 32'hDEAD_BEE0},
    {2'd0, 9'h0AB, 8'h5A, 8'h0C, 12'h800, 8'h02, 32'h8000_0004},
    {2'd0, 9'h001, 8'h77, 8'h66, 12'h123, 8'h09, 32'h0BAD_0000},
    {2'd2, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd1, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd3, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd2, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd1, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd1, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd2, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000},
    {2'd0, 9'h070, 8'h11, 8'h22, 12'h333, 8'h04, 32'h0000_0040},
    {2'd1, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_req = 1'b0;
  logic [8:0] trap_type = '0;
  logic [1:0] ret_cmd = 2'b00;
  logic [PCW-1:0] cur_pc = '0, cur_npc = '0;
  logic [7:0] cur_cc = '0, cur_asi = '0, cur_cwp = '0;
  logic [11:0] cur_pstate = '0;
  logic redirect_vld, error_state, illegal_ret;
  logic [PCW-1:0] new_pc, new_npc;
  logic [7:0] new_cc, new_asi, new_cwp;
  logic [11:0] new_pstate;
  logic [8:0] new_tt;
  logic [LW-1:0] trap_level;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference stack kept by the bench
  int m_lvl = 0;
  logic [PCW-1:0] m_pc [MAXL];
  logic [PCW-1:0] m_npc [MAXL];
  logic [7:0] m_cc [MAXL];
  logic [7:0] m_asi [MAXL];
  logic [11:0] m_ps [MAXL];
  logic [7:0] m_cwp [MAXL];
  logic [8:0] m_tt [MAXL];

  always #2 clk = ~clk;

  trap_stack #(.MAX_LVL(MAXL), .PC_W(PCW), .CC_W(8)) dut_i (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
    .ret_cmd(ret_cmd), .tba_hi(TBA_HI), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .cur_cc(cur_cc), .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_cwp(cur_cwp),
    .redirect_vld(redirect_vld), .new_pc(new_pc), .new_npc(new_npc),
    .new_cc(new_cc), .new_asi(new_asi), .new_pstate(new_pstate), .new_cwp(new_cwp),
    .new_tt(new_tt), .trap_level(trap_level), .error_state(error_state),
    .illegal_ret(illegal_ret)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic dotrap, input logic [1:0] cmd, input logic [8:0] tt,
                       input logic [7:0] cc, input logic [7:0] asi, input logic [11:0] ps,
                       input logic [7:0] cwp, input logic [31:0] p);
    logic [PCW-1:0] pc64, npc64, e_pc, e_npc;
    logic [7:0] e_cc, e_asi, e_cwp;
    logic [11:0] e_ps;
    logic [8:0] e_tt;
    logic e_rd, e_err, e_bad, is_entry;
    pc64 = {p, ~p};
    npc64 = pc64 + 64'h10;
    e_pc = '0; e_npc = '0; e_cc = '0; e_asi = '0; e_cwp = '0; e_ps = '0; e_tt = '0;
    e_rd = 0; e_err = 0; e_bad = 0; is_entry = 0;
    @(negedge clk);
    trap_req = dotrap; ret_cmd = cmd; trap_type = tt;
    cur_pc = pc64; cur_npc = npc64; cur_cc = cc; cur_asi = asi; cur_pstate = ps; cur_cwp = cwp;
    if (dotrap) begin
      if (m_lvl == MAXL) begin
        e_err = 1;
      end else begin
        m_pc[m_lvl] = pc64; m_npc[m_lvl] = npc64; m_cc[m_lvl] = cc; m_asi[m_lvl] = asi;
        m_ps[m_lvl] = ps; m_cwp[m_lvl] = cwp; m_tt[m_lvl] = tt;
        e_rd = 1; is_entry = 1;
        e_pc = {TBA_HI, (m_lvl > 1), tt, 5'b00000};
        e_npc = e_pc + 64'd4;
        e_ps = (m_lvl >= MAXL - 1) ? 12'h035 : 12'h015;
        e_cc = cc; e_asi = asi; e_cwp = cwp; e_tt = tt;
        m_lvl++;
      end
    end else if (cmd == 2'b01 || cmd == 2'b10) begin
      if (m_lvl == 0) begin
        e_bad = 1;
      end else begin
        m_lvl--;
        e_rd = 1;
        e_pc = (cmd == 2'b01) ? m_pc[m_lvl] : m_npc[m_lvl];
        e_npc = (cmd == 2'b01) ? m_npc[m_lvl] : m_npc[m_lvl] + 64'd4;
        e_cc = m_cc[m_lvl]; e_asi = m_asi[m_lvl]; e_cwp = m_cwp[m_lvl];
        e_ps = m_ps[m_lvl] & 12'hF3F; e_tt = m_tt[m_lvl];
      end
    end
    @(negedge clk);
    trap_req = 0; ret_cmd = 2'b00;
    chk("R5 level", 64'(trap_level), 64'(m_lvl));
    chk("R7 error_state", 64'(error_state), 64'(e_err));
    chk("R11 illegal_ret", 64'(illegal_ret), 64'(e_bad));
    chk("R12 redirect_vld", 64'(redirect_vld), 64'(e_rd));
    if (e_rd) begin
      if (is_entry) begin
        chk("R3 entry pc", new_pc, e_pc);
        chk("R3 entry npc", new_npc, e_npc);
        chk("R6 entry pstate", 64'(new_pstate), 64'(e_ps));
        chk("R4 entry cc/asi/cwp", {40'd0, new_cc, new_asi, new_cwp}, {40'd0, e_cc, e_asi, e_cwp});
        chk("R4 entry tt", 64'(new_tt), 64'(e_tt));
      end else begin
        chk((cmd == 2'b01) ? "R8 retry pc" : "R9 done pc", new_pc, e_pc);
        chk((cmd == 2'b01) ? "R8 retry npc" : "R9 done npc", new_npc, e_npc);
        chk("R2 restored pstate", 64'(new_pstate), 64'(e_ps));
        chk("R10 restored cc/asi/cwp", {40'd0, new_cc, new_asi, new_cwp}, {40'd0, e_cc, e_asi, e_cwp});
        chk("R10 restored tt", 64'(new_tt), 64'(e_tt));
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 level in reset", 64'(trap_level), 64'd0);
    chk("R1 strobes in reset", {61'd0, redirect_vld, error_state, illegal_ret}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 level after reset", 64'(trap_level), 64'd0);
    chk("R1 strobes after reset", {61'd0, redirect_vld, error_state, illegal_ret}, 64'd0);

    // table walk: climb to the top, fault, mixed pops, reserved code, pop at zero
    for (int i = 0; i < 15; i++) begin
      logic [78:0] v;
      v = VEC[i];
      if (v[78:77] == 2'd0)
        apply(1'b1, 2'b00, v[76:68], v[67:60], v[59:52], v[51:40], v[39:32], v[31:0]);
      else
        apply(1'b0, v[78:77], v[76:68], v[67:60], v[59:52], v[51:40], v[39:32], v[31:0]);
    end

    // R12: trap and retry together, trap wins
    apply(1'b1, 2'b01, 9'h0F0, 8'hC3, 8'h19, 12'h0FF, 8'h06, 32'hABCD_0000);
    // R12: reserved code while one level deep
    apply(1'b0, 2'b11, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0);
    apply(1'b0, 2'b10, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0);

    // R1: reset with a non-empty stack
    apply(1'b1, 2'b00, 9'h033, 8'h44, 8'h55, 12'h666, 8'h07, 32'h0000_2000);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R1 level after mid-stack reset", 64'(trap_level), 64'd0);
    rst = 0;
    m_lvl = 0;
    // R11: return right after reset is illegal
    apply(1'b0, 2'b01, 9'h000, 8'h00, 8'h00, 12'h000, 8'h00, 32'h0);

    summary();
  end

endmodule